// File: doc/BRIEF.md
# Chained Vector Multiply-Add Datapath

This block evaluates Y = a·X + Y over a vector of signed 32-bit fixed-point elements. A start pulse loads the vector length and the scalar. X and Y elements then arrive as two valid-qualified streams, one pair per cycle. Each pair first passes through a vector-by-scalar multiply pipeline and then through an add pipeline. The two pipelines are chained: the adder takes each product in the cycle it leaves the multiplier, so the whole vector flows through both units as a single overlapped operation. Only the first element pays the full pipeline fill.

The Y element travels beside its X element through the multiply stages. It therefore meets its own product at the adder input. Results leave on a valid-qualified stream tagged with the element index. A done pulse marks the end of the vector. Every product and sum wraps modulo 2^32.

Top module: `axpy_chain`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `res_valid`, `done` and `busy` are 0.
- R2: Each result equals the low 32 bits of a·X[i] + Y[i]. All three operands are taken as signed two's complement. Overflow wraps silently and raises no flag.
- R3: The block accepts one element per cycle. An element sampled at clock edge E produces its result, with `res_valid` high, right after edge E+12 (7 multiply stages followed by 6 add stages).
- R4: An element is taken only at an edge where `x_valid` and `y_valid` are both 1, `busy` is 1, and fewer than VL elements of the vector have already been taken. Any other input cycle produces no result.
- R5: A vector produces exactly VL results. `done` is 1 for one cycle, the cycle after the last result, and `busy` falls at the same edge.
- R6: `res_idx` counts 0, 1, …, VL−1 over the results of a vector, in order.
- R7: A start pulse sets `busy` and loads `vlen` and `scalar_a`. It has effect only when `busy` is 0 and 1 ≤ `vlen` ≤ 64. Otherwise it is ignored.
- R8: The scalar is captured at the accepted start pulse. Later changes on `scalar_a` do not affect that vector.
- R9: When X/Y are presented on every cycle from the cycle after start onward, the last result appears VL+12 cycles after the cycle in which the first element was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a vector |
| vlen | input | 7 | Vector length, 1..64 |
| scalar_a | input | 32 | Signed scalar multiplier |
| x_valid | input | 1 | X element present |
| x_data | input | 32 | Signed X element |
| y_valid | input | 1 | Y element present |
| y_data | input | 32 | Signed Y element |
| res_valid | output | 1 | Result present |
| res_data | output | 32 | Signed result a·X+Y |
| res_idx | output | 6 | Element index of the result |
| done | output | 1 | One-cycle end-of-vector pulse |
| busy | output | 1 | Vector in progress |

## Verification
The hardest situation to reach is a start pulse arriving after all inputs have been taken but while the chained pipelines are still draining. The block looks idle at its input side, yet it must refuse the new vector. The stimulus reaches it by over-feeding a short vector and then pulsing start, with a different length, inside the 13-cycle drain window. Other cases are handled by the same comparison with the bench's model: gaps where only one stream is valid, with the scalar changed during those gaps; and operands near the 32-bit limits, where the product and the sum must wrap.

// File: rtl/axpy_pkg.sv
package axpy_pkg;
  parameter int unsigned DW = 32;

  // low DW bits of the signed product
  function automatic logic [DW-1:0] wrap_mul(input logic [DW-1:0] a, input logic [DW-1:0] x);
    logic signed [2*DW-1:0] full;
    full = $signed(a) * $signed(x);
    return full[DW-1:0];
  endfunction

  // modulo-2^DW sum, no overflow reporting
  function automatic logic [DW-1:0] wrap_add(input logic [DW-1:0] p, input logic [DW-1:0] y);
    return p + y;
  endfunction
endpackage

// File: rtl/vpipe_delay.sv
module vpipe_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_in,
  input  logic [W-1:0] d_in,
  output logic         v_out,
  output logic [W-1:0] d_out
);
  logic [DEPTH-1:0] v_q;
  logic [W-1:0]     d_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) v_q[0] <= 1'b0;
    else        v_q[0] <= v_in;
    d_q[0] <= d_in;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) v_q[k] <= 1'b0;
      else        v_q[k] <= v_q[k-1];
      d_q[k] <= d_q[k-1];
    end
    // R3: a valid token advances exactly one stage per clock
    a_r3_stage_advance: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[k-1] |=> v_q[k]);
  end

  assign v_out = v_q[DEPTH-1];
  assign d_out = d_q[DEPTH-1];
endmodule

// File: rtl/axpy_mul_unit.sv
module axpy_mul_unit
  import axpy_pkg::*;
#(
  parameter int LAT = 7,
  parameter int IW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_in,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic [IW-1:0] idx,
  output logic          v_out,
  output logic [DW-1:0] prod,
  output logic [DW-1:0] y_out,
  output logic [IW-1:0] idx_out
);
  localparam int PW = 2*DW + IW;
  logic [PW-1:0] pk_in, pk_out;

  // Y and index ride alongside the product so Y meets product i at the adder
  assign pk_in = {wrap_mul(a, x), y, idx};

  vpipe_delay #(.W(PW), .DEPTH(LAT)) u_line (
    .clk(clk), .rst_n(rst_n), .v_in(v_in), .d_in(pk_in),
    .v_out(v_out), .d_out(pk_out)
  );

  assign prod    = pk_out[PW-1 -: DW];
  assign y_out   = pk_out[IW +: DW];
  assign idx_out = pk_out[IW-1:0];
endmodule

// File: rtl/axpy_add_unit.sv
module axpy_add_unit
  import axpy_pkg::*;
#(
  parameter int LAT = 6,
  parameter int IW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_in,
  input  logic [DW-1:0] p,
  input  logic [DW-1:0] y,
  input  logic [IW-1:0] idx,
  output logic          v_out,
  output logic [DW-1:0] sum,
  output logic [IW-1:0] idx_out
);
  localparam int SW = DW + IW;
  logic [SW-1:0] pk_out;

  vpipe_delay #(.W(SW), .DEPTH(LAT)) u_line (
    .clk(clk), .rst_n(rst_n), .v_in(v_in), .d_in({wrap_add(p, y), idx}),
    .v_out(v_out), .d_out(pk_out)
  );

  assign sum     = pk_out[SW-1 -: DW];
  assign idx_out = pk_out[IW-1:0];
endmodule

// File: rtl/axpy_ctrl.sv
module axpy_ctrl
  import axpy_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int VW     = 7,
  parameter int IW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VW-1:0] vlen,
  input  logic [DW-1:0] scalar_a,
  input  logic          x_valid,
  input  logic          y_valid,
  input  logic          res_valid,
  input  logic [IW-1:0] res_idx,
  output logic          accept,
  output logic [IW-1:0] in_idx,
  output logic [DW-1:0] a_q,
  output logic          busy,
  output logic          done
);
  logic [VW-1:0] vl_r, in_cnt, out_cnt;
  logic start_ok, last_out;

  assign start_ok = start && !busy && (vlen != '0) && (vlen <= VW'(MAX_VL));
  assign accept   = busy && (in_cnt < vl_r) && x_valid && y_valid;
  assign last_out = res_valid && (out_cnt == vl_r - VW'(1));
  assign in_idx   = in_cnt[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; vl_r <= '0;
      in_cnt <= '0; out_cnt <= '0; a_q <= '0;
    end else begin
      done <= last_out;
      if (start_ok) begin
        busy <= 1'b1; vl_r <= vlen; a_q <= scalar_a;
        in_cnt <= '0; out_cnt <= '0;
      end else begin
        if (accept)    in_cnt  <= in_cnt + VW'(1);
        if (res_valid) out_cnt <= out_cnt + VW'(1);
        if (last_out)  busy    <= 1'b0;
      end
    end
  end

  a_r6_idx_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_idx == out_cnt[IW-1:0]));
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(res_valid));
  a_r5_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r4_no_result_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !res_valid);
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= vl_r);
  a_r7_start_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(vl_r));
  a_r8_scalar_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(a_q));
endmodule

// File: rtl/axpy_chain.sv
module axpy_chain
  import axpy_pkg::*;
#(
  parameter int MAX_VL  = 64,
  parameter int MUL_LAT = 7,
  parameter int ADD_LAT = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [$clog2(MAX_VL+1)-1:0]   vlen,
  input  logic [DW-1:0]                 scalar_a,
  input  logic                          x_valid,
  input  logic [DW-1:0]                 x_data,
  input  logic                          y_valid,
  input  logic [DW-1:0]                 y_data,
  output logic                          res_valid,
  output logic [DW-1:0]                 res_data,
  output logic [$clog2(MAX_VL)-1:0]     res_idx,
  output logic                          done,
  output logic                          busy
);
  localparam int VW = $clog2(MAX_VL+1);
  localparam int IW = $clog2(MAX_VL);

  logic          accept;
  logic [IW-1:0] in_idx, m_idx;
  logic [DW-1:0] a_q, m_prod, m_y;
  logic          m_v;

  axpy_ctrl #(.MAX_VL(MAX_VL), .VW(VW), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .scalar_a(scalar_a),
    .x_valid(x_valid), .y_valid(y_valid), .res_valid(res_valid), .res_idx(res_idx),
    .accept(accept), .in_idx(in_idx), .a_q(a_q), .busy(busy), .done(done)
  );

  axpy_mul_unit #(.LAT(MUL_LAT), .IW(IW)) u_mul (
    .clk(clk), .rst_n(rst_n), .v_in(accept), .a(a_q), .x(x_data), .y(y_data),
    .idx(in_idx), .v_out(m_v), .prod(m_prod), .y_out(m_y), .idx_out(m_idx)
  );

  // chained: adder consumes each product the cycle it leaves the multiplier
  axpy_add_unit #(.LAT(ADD_LAT), .IW(IW)) u_add (
    .clk(clk), .rst_n(rst_n), .v_in(m_v), .p(m_prod), .y(m_y), .idx(m_idx),
    .v_out(res_valid), .sum(res_data), .idx_out(res_idx)
  );

  a_r4_product_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    m_v |-> busy);
endmodule

// File: tb/sim_axpy_chain.sv
`timescale 1ns/1ps
module sim_axpy_chain;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [6:0] vlen = '0;
  logic [31:0] scal = '0, xd = '0, yd = '0;
  logic xv = 1'b0, yv = 1'b0;
  logic res_valid, done, busy;
  logic [31:0] res_data;
  logic [5:0] res_idx;

  always #2 clk = ~clk; // 250 MHz

  axpy_chain u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .scalar_a(scal),
    .x_valid(xv), .x_data(xd), .y_valid(yv), .y_data(yd),
    .res_valid(res_valid), .res_data(res_data), .res_idx(res_idx),
    .done(done), .busy(busy)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // ---- behavioural reference: expected outputs keyed by cycle number ----
  int cyc = 0;
  int exp_d [int];
  int exp_i [int];
  bit m_busy = 0;
  int m_vl = 0, m_acc = 0, done_key = -1, first_cyc = 0;
  int m_a = 0;
  bit lat_chk = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; done_key = -1; cyc = 0;
    end else begin
      cyc++;
      if (m_busy) begin
        if (m_acc < m_vl && xv && yv) begin
          longint full;
          full = longint'($signed(m_a)) * longint'($signed(xd)) + longint'($signed(yd));
          exp_d[cyc+12] = int'(full);
          exp_i[cyc+12] = m_acc;
          if (m_acc == 0) first_cyc = cyc - 1;
          m_acc++;
          if (m_acc == m_vl) done_key = cyc + 13;
        end
        if (cyc == done_key) m_busy = 0;
      end else if (start && vlen >= 1 && vlen <= 64) begin
        m_busy = 1; m_vl = int'(vlen); m_a = int'(scal); m_acc = 0; done_key = -1;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cyc > 0) begin
      bit ev;
      ev = exp_d.exists(cyc);
      chk(res_valid == ev, "R3 R4 res_valid", int'(res_valid), int'(ev));
      if (ev && res_valid) begin
        chk(res_data == exp_d[cyc], "R2 R8 res_data", int'(res_data), exp_d[cyc]);
        chk(int'(res_idx) == exp_i[cyc], "R6 res_idx", int'(res_idx), exp_i[cyc]);
        if (lat_chk && exp_i[cyc] == m_vl - 1)
          chk(cyc - first_cyc == m_vl + 12, "R9 latency", cyc - first_cyc, m_vl + 12);
      end
      chk(done == (cyc == done_key), "R5 done", int'(done), int'(cyc == done_key));
      chk(busy == (m_busy || cyc == done_key) && !(cyc == done_key) || (busy == m_busy),
          "R5 R7 busy", int'(busy), int'(m_busy));
    end
  end

  task automatic start_vec(int n, logic [31:0] av);
    @(negedge clk); start = 1; vlen = 7'(n); scal = av;
    @(negedge clk); start = 0;
  endtask

  task automatic feed(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        // R4: one stream valid alone is not taken; R8: scalar change ignored
        xv = 1; yv = 0; xd = $urandom; yd = $urandom; scal = $urandom;
        @(negedge clk);
        xv = 0; yv = 1;
        @(negedge clk);
      end
      xv = 1; yv = 1; xd = $urandom; yd = $urandom;
      @(negedge clk);
    end
    xv = 0; yv = 0;
  endtask

  task automatic feed_val(logic [31:0] x, logic [31:0] y);
    xv = 1; yv = 1; xd = x; yd = y;
    @(negedge clk);
    xv = 0; yv = 0;
  endtask

  task automatic settle();
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!res_valid && !done && !busy, "R1 reset", int'({res_valid, done, busy}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!res_valid && !done && !busy, "R1 after reset", int'({res_valid, done, busy}), 0);

    // R3 R9: single element, continuous
    lat_chk = 1;
    start_vec(1, 32'd3); feed(1, 0); settle();
    // R9: full-length vector, continuous
    start_vec(64, $urandom); feed(64, 0); settle();
    lat_chk = 0;

    // R4 R8: gapped streams with scalar toggling
    start_vec(8, -32'sd5); feed(8, 1); settle();

    // R2: wrap-around operands
    start_vec(4, 32'h7fff_ffff);
    feed_val(32'h7fff_ffff, 32'h7fff_ffff);
    feed_val(32'h8000_0000, 32'h8000_0000);
    feed_val(32'hffff_ffff, 32'h0000_0001);
    feed_val(32'h0000_0002, 32'h7fff_ffff);
    settle();

    // R4 R7: over-feed, then start during drain is refused
    start_vec(3, 32'd7); feed(6, 0);
    start_vec(10, 32'd9);
    feed(4, 0);
    settle();

    // R7: illegal lengths ignored, inputs produce nothing
    start_vec(0, 32'd1); feed(2, 0);
    start_vec(65, 32'd1); feed(2, 0);
    repeat (20) @(negedge clk);

    // back-to-back vectors
    start_vec(5, 32'hffff_fff0); feed(5, 0); settle();
    start_vec(2, 32'd0); feed(2, 0); settle();

    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end
endmodule